// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timing Generator

This block produces the chip-select, write strobe and read strobe for one access on an 8080-style parallel display bus. It also picks the clock edge at which read data is captured. Every strobe edge sits at a tick count of its own inside the access. The counts come from two packed 32-bit timing words that are loaded while the bus is idle. A tick lasts either one clock or two clocks, as selected when the words are loaded.

When the words are loaded, the block enforces the ordering rules between the edges. A field that would break a rule is raised to the smallest value that meets it, and a sticky warning flag is set. A requester presents a read or write request while the block is ready. The block then runs the strobes through one access, latches the read data bus when the tick count reaches the access time, and pulses done once the access is over. A request that is waiting is taken on the final clock of the current access, so its first tick follows the last tick of that access with no gap.

Top module: `pbus_strobe_gen`

## Requirements
- R1: Timing word 0 holds the chip-select on time in bits 3:0 and its off time in bits 9:4. It holds the write strobe on time in bits 13:10 and its off time in bits 19:14. It holds the read strobe on time in bits 23:20 and its off time in bits 29:24. Timing word 1 holds the write access length in bits 5:0, the read access length in bits 11:6 and the access time in bits 27:22. All other bits have no effect. On times are 4 bits wide and all other fields are 6 bits wide.
- R2: Ticks are counted from 0, starting at the first tick of an access. A strobe is active while the tick count is at or above its on time and below its off time. Chip-select is used by both reads and writes. The write strobe is active only in writes and the read strobe only in reads.
- R3: A write lasts write-length ticks and a read lasts read-length ticks. `done` is high for exactly the one clock that follows the last clock of an access.
- R4: With `tim_x2` = 0 a tick is one clock. With `tim_x2` = 1 a tick is two clocks. The setting is captured with the timing words.
- R5: On load, fields are raised to the smallest legal value so that these rules hold: write off > write on, read off > read on, chip-select off > chip-select on, chip-select off >= both strobe off times, write length >= write off, read length >= read off, access time > read on, and read length >= access time.
- R6: `clamp_warn` is set by any load that raised a field. Only reset clears it.
- R7: `rd_data` captures `rd_bus` at the clock edge where the tick count of a read reaches the access time, and holds that value otherwise. `rd_valid` is high together with `done`, and only after reads.
- R8: `req_ready` is high while idle and in the last clock of an access. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. The first tick of the new access starts in the next clock.
- R9: A `tim_load` while an access is in progress, including its last clock, has no effect.
- R10: A polarity input of 1 makes that output active-high, and 0 makes it active-low. Outputs rest at their inactive level when idle.
- R11: After reset the block is idle with `clamp_warn`, `done`, `rd_valid` and `rd_data` at 0. The timing is as follows: chip-select, write strobe and read strobe each on at tick 0 and off at tick 1; both lengths 1 tick; access time 1; one clock per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tim_load | input | 1 | Load the timing words and tick setting |
| tim_w0 | input | 32 | Strobe on/off timing word |
| tim_w1 | input | 32 | Length and access time word |
| tim_x2 | input | 1 | 1: two clocks per tick |
| pol_cs | input | 1 | Chip-select polarity (1 = active-high) |
| pol_we | input | 1 | Write strobe polarity |
| pol_re | input | 1 | Read strobe polarity |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1: write access, 0: read access |
| req_ready | output | 1 | Request can be taken at this edge |
| rd_bus | input | DATA_W | Read data from the bus |
| cs_o | output | 1 | Chip-select pin |
| we_o | output | 1 | Write strobe pin |
| re_o | output | 1 | Read strobe pin |
| done | output | 1 | Access finished (one clock) |
| rd_valid | output | 1 | Read data valid (one clock) |
| rd_data | output | DATA_W | Captured read data |
| clamp_warn | output | 1 | Sticky: a load was corrected |

## Verification
The strobes and `req_ready` are decoded from registered state. They therefore change in the clock that follows the edge at which a request is taken, and that clock is tick 0. `done`, `rd_valid` and a new `rd_data` appear one clock after the final or sampling edge. A new configuration and `clamp_warn` appear one clock after the load edge. The bench advances a behavioural model at each rising edge from the inputs that were stable before that edge. It then compares every output two nanoseconds later, in the same clock the design is due to change. Because of this, an output that is one clock early or late fails the comparison.

// File: rtl/pbus_pkg.sv
// Shared types for the parallel bus strobe generator.
// Assumes the fixed 32-bit packed timing word format described in the brief.
package pbus_pkg;
    localparam int WORD_W = 32;
    localparam int ON_W   = 4;
    localparam int OFF_W  = 6;

    typedef struct packed {
        logic [ON_W-1:0]  cs_on;
        logic [ON_W-1:0]  we_on;
        logic [ON_W-1:0]  re_on;
        logic [OFF_W-1:0] cs_off;
        logic [OFF_W-1:0] we_off;
        logic [OFF_W-1:0] re_off;
        logic [OFF_W-1:0] wr_len;
        logic [OFF_W-1:0] rd_len;
        logic [OFF_W-1:0] acc;
        logic             x2;
    } pbus_tim_t;

    localparam pbus_tim_t TIM_RESET = '{cs_on: 4'd0, we_on: 4'd0, re_on: 4'd0,
                                        cs_off: 6'd1, we_off: 6'd1, re_off: 6'd1,
                                        wr_len: 6'd1, rd_len: 6'd1, acc: 6'd1,
                                        x2: 1'b0};

    // Splits the two timing words into named fields.
    function automatic pbus_tim_t unpack_words(input logic [WORD_W-1:0] w0,
                                               input logic [WORD_W-1:0] w1,
                                               input logic x2);
        pbus_tim_t t;
        t.cs_on  = w0[3:0];
        t.cs_off = w0[9:4];
        t.we_on  = w0[13:10];
        t.we_off = w0[19:14];
        t.re_on  = w0[23:20];
        t.re_off = w0[29:24];
        t.wr_len = w1[5:0];
        t.rd_len = w1[11:6];
        t.acc    = w1[27:22];
        t.x2     = x2;
        return t;
    endfunction
endpackage

// File: rtl/pbus_tim_clamp.sv
// Raises timing fields to the smallest values that satisfy the edge ordering rules.
// Purely combinational; assumes on times are narrower than off times, so on+1 never overflows.
module pbus_tim_clamp
    import pbus_pkg::*;
(
    input  pbus_tim_t raw,
    output pbus_tim_t fixed,
    output logic      raised
);
    // Apply each rule in dependency order: strobe offs first, then the fields bounded by them.
    always_comb begin
        fixed = raw;
        if (fixed.we_off <= OFF_W'(fixed.we_on)) fixed.we_off = OFF_W'(fixed.we_on) + OFF_W'(1);
        if (fixed.re_off <= OFF_W'(fixed.re_on)) fixed.re_off = OFF_W'(fixed.re_on) + OFF_W'(1);
        if (fixed.cs_off <= OFF_W'(fixed.cs_on)) fixed.cs_off = OFF_W'(fixed.cs_on) + OFF_W'(1);
        if (fixed.cs_off < fixed.we_off)         fixed.cs_off = fixed.we_off;
        if (fixed.cs_off < fixed.re_off)         fixed.cs_off = fixed.re_off;
        if (fixed.acc <= OFF_W'(fixed.re_on))    fixed.acc    = OFF_W'(fixed.re_on) + OFF_W'(1);
        if (fixed.wr_len < fixed.we_off)         fixed.wr_len = fixed.we_off;
        if (fixed.rd_len < fixed.re_off)         fixed.rd_len = fixed.re_off;
        if (fixed.rd_len < fixed.acc)            fixed.rd_len = fixed.acc;
        raised = (fixed != raw);
    end
endmodule

// File: rtl/pbus_cycle_ctr.sv
// Access sequencer: tick prescaler, tick counter and request hand-off.
// Assumes the lengths are at least 1 and stay stable while busy.
module pbus_cycle_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x2,
    input  logic [CNT_W-1:0] wr_len,
    input  logic [CNT_W-1:0] rd_len,
    input  logic             req_valid,
    input  logic             req_write,
    output logic             busy,
    output logic             is_wr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nx,
    output logic             tick_end,
    output logic             last,
    output logic             ready
);
    logic             ph;
    logic [CNT_W-1:0] len;
    logic             accept;

    // Decode tick boundaries and the final clock of the access.
    always_comb begin
        len      = is_wr ? wr_len : rd_len;
        cnt_nx   = cnt + CNT_W'(1);
        tick_end = busy & (~x2 | ph);
        last     = tick_end & (cnt_nx == len);
        ready    = ~busy | last;
        accept   = req_valid & ready;
    end

    // Advance the access state; a taken request restarts at tick 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            ph    <= 1'b0;
            cnt   <= '0;
            is_wr <= 1'b0;
        end else if (accept) begin
            busy  <= 1'b1;
            ph    <= 1'b0;
            cnt   <= '0;
            is_wr <= req_write;
        end else if (last) begin
            busy  <= 1'b0;
            ph    <= 1'b0;
            cnt   <= '0;
        end else if (busy) begin
            ph <= x2 & ~ph;
            if (tick_end) cnt <= cnt_nx;
        end
    end
endmodule

// File: rtl/pbus_strobe_dec.sv
// Turns the tick count into the three pin levels, one window compare per pin.
// Index 0 is chip-select, 1 the write strobe, 2 the read strobe.
module pbus_strobe_dec #(
    parameter int CNT_W = 6,
    parameter int NPIN  = 3
) (
    input  logic [NPIN-1:0]            en,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [NPIN-1:0][CNT_W-1:0] on_t,
    input  logic [NPIN-1:0][CNT_W-1:0] off_t,
    input  logic [NPIN-1:0]            pol,
    output logic [NPIN-1:0]            pin
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic act;
        // Active inside [on, off) and only when enabled for this access.
        assign act    = en[i] & (cnt >= on_t[i]) & (cnt < off_t[i]);
        assign pin[i] = pol[i] ? act : ~act;
    end
endmodule

// File: rtl/pbus_strobe_gen.sv
// Top: timing configuration, clamp, sequencer, strobe decode and read capture.
// Assumes loads arrive only through tim_load and are dropped while an access runs.
module pbus_strobe_gen
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tim_load,
    input  logic [31:0]       tim_w0,
    input  logic [31:0]       tim_w1,
    input  logic              tim_x2,
    input  logic              pol_cs,
    input  logic              pol_we,
    input  logic              pol_re,
    input  logic              req_valid,
    input  logic              req_write,
    output logic              req_ready,
    input  logic [DATA_W-1:0] rd_bus,
    output logic              cs_o,
    output logic              we_o,
    output logic              re_o,
    output logic              done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              clamp_warn
);
    localparam int NPIN = 3;

    pbus_tim_t cfg_q, raw_cfg, fixed_cfg;
    logic      raised, load_en;
    logic      busy, is_wr, tick_end, last;
    logic [OFF_W-1:0] cnt, cnt_nx;
    logic [NPIN-1:0][OFF_W-1:0] on_t, off_t;
    logic [NPIN-1:0] pins;
    logic      unused_fields;

    assign raw_cfg       = unpack_words(tim_w0, tim_w1, tim_x2);
    assign unused_fields = ^{tim_w0[31:30], tim_w1[21:12], tim_w1[31:28]};
    assign load_en       = tim_load & ~busy;

    pbus_tim_clamp u_clamp (
        .raw    (raw_cfg),
        .fixed  (fixed_cfg),
        .raised (raised)
    );

    // Timing store: takes the corrected words only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= TIM_RESET;
        else if (load_en) cfg_q <= fixed_cfg;
    end

    // Sticky warning for any corrected load.
    always_ff @(posedge clk) begin
        if (!rst_n)                 clamp_warn <= 1'b0;
        else if (load_en && raised) clamp_warn <= 1'b1;
    end

    pbus_cycle_ctr #(.CNT_W(OFF_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .x2        (cfg_q.x2),
        .wr_len    (cfg_q.wr_len),
        .rd_len    (cfg_q.rd_len),
        .req_valid (req_valid),
        .req_write (req_write),
        .busy      (busy),
        .is_wr     (is_wr),
        .cnt       (cnt),
        .cnt_nx    (cnt_nx),
        .tick_end  (tick_end),
        .last      (last),
        .ready     (req_ready)
    );

    assign on_t  = {OFF_W'(cfg_q.re_on), OFF_W'(cfg_q.we_on), OFF_W'(cfg_q.cs_on)};
    assign off_t = {cfg_q.re_off, cfg_q.we_off, cfg_q.cs_off};

    pbus_strobe_dec #(.CNT_W(OFF_W), .NPIN(NPIN)) u_dec (
        .en    ({busy & ~is_wr, busy & is_wr, busy}),
        .cnt   (cnt),
        .on_t  (on_t),
        .off_t (off_t),
        .pol   ({pol_re, pol_we, pol_cs}),
        .pin   (pins)
    );

    assign cs_o = pins[0];
    assign we_o = pins[1];
    assign re_o = pins[2];

    // End-of-access pulses, one clock after the final edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            done     <= last;
            rd_valid <= last & ~is_wr;
        end
    end

    // Read capture at the edge where the tick count reaches the access time.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         rd_data <= '0;
        else if (tick_end && !is_wr && cnt_nx == cfg_q.acc) rd_data <= rd_bus;
    end
endmodule

// File: rtl/pbus_strobe_gen_chk.sv
// Protocol checker for pbus_strobe_gen, attached with bind below.
module pbus_strobe_gen_chk
    import pbus_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      busy,
    input pbus_tim_t cfg,
    input logic      cs_o,
    input logic      we_o,
    input logic      re_o,
    input logic      pol_cs,
    input logic      pol_we,
    input logic      pol_re,
    input logic      req_ready,
    input logic      done,
    input logic      rd_valid,
    input logic      clamp_warn
);
    logic cs_act, we_act, re_act;
    assign cs_act = ~(cs_o ^ pol_cs);
    assign we_act = ~(we_o ^ pol_we);
    assign re_act = ~(re_o ^ pol_re);

    // R5
    order_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.we_off > OFF_W'(cfg.we_on) && cfg.re_off > OFF_W'(cfg.re_on) &&
        cfg.cs_off > OFF_W'(cfg.cs_on) && cfg.cs_off >= cfg.we_off &&
        cfg.cs_off >= cfg.re_off && cfg.wr_len >= cfg.we_off &&
        cfg.rd_len >= cfg.re_off && cfg.acc > OFF_W'(cfg.re_on) &&
        cfg.rd_len >= cfg.acc);
    // R6
    warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_warn |=> clamp_warn);
    // R9
    cfg_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg));
    // R2
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_act && re_act));
    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cs_act && !we_act && !re_act));
    // R8
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> req_ready);
    // R7
    rdv_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> done);
    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

bind pbus_strobe_gen pbus_strobe_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cfg        (cfg_q),
    .cs_o       (cs_o),
    .we_o       (we_o),
    .re_o       (re_o),
    .pol_cs     (pol_cs),
    .pol_we     (pol_we),
    .pol_re     (pol_re),
    .req_ready  (req_ready),
    .done       (done),
    .rd_valid   (rd_valid),
    .clamp_warn (clamp_warn)
);

// File: tb/tb_pbus_strobe_gen.sv
`timescale 1ns/1ps
module tb_pbus_strobe_gen;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tim_load = 1'b0;
    logic [31:0] tim_w0 = '0, tim_w1 = '0;
    logic tim_x2 = 1'b0;
    logic pol_cs = 1'b0, pol_we = 1'b0, pol_re = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [DW-1:0] rd_bus = 16'h1234;
    logic cs_o, we_o, re_o, done, rd_valid, clamp_warn;
    logic [DW-1:0] rd_data;

    always #4 clk = ~clk;

    pbus_strobe_gen #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .tim_load(tim_load), .tim_w0(tim_w0),
        .tim_w1(tim_w1), .tim_x2(tim_x2), .pol_cs(pol_cs), .pol_we(pol_we),
        .pol_re(pol_re), .req_valid(req_valid), .req_write(req_write),
        .req_ready(req_ready), .rd_bus(rd_bus), .cs_o(cs_o), .we_o(we_o),
        .re_o(re_o), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
        .clamp_warn(clamp_warn)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 0;
    string phase = "R11 reset";

    // Behavioural model state
    int m_cson, m_csoff, m_weon, m_weoff, m_reon, m_reoff, m_wrlen, m_rdlen, m_acc;
    bit m_x2, m_warn, m_busy, m_wr, m_done, m_rdv, m_evt, m_started;
    int m_clk;
    int m_rdata;

    task automatic m_reset();
        m_cson = 0; m_csoff = 1; m_weon = 0; m_weoff = 1; m_reon = 0; m_reoff = 1;
        m_wrlen = 1; m_rdlen = 1; m_acc = 1; m_x2 = 0; m_warn = 0;
        m_busy = 0; m_wr = 0; m_done = 0; m_rdv = 0; m_clk = 0; m_rdata = 0; m_evt = 0;
    endtask

    // R1 field positions, R5 raising rules, R6 warning
    task automatic m_load(input logic [31:0] w0, input logic [31:0] w1, input bit x2);
        bit r = 0;
        m_cson = w0 & 32'hF; m_csoff = (w0 >> 4) & 32'h3F;
        m_weon = (w0 >> 10) & 32'hF; m_weoff = (w0 >> 14) & 32'h3F;
        m_reon = (w0 >> 20) & 32'hF; m_reoff = (w0 >> 24) & 32'h3F;
        m_wrlen = w1 & 32'h3F; m_rdlen = (w1 >> 6) & 32'h3F; m_acc = (w1 >> 22) & 32'h3F;
        m_x2 = x2;
        if (m_weoff < m_weon + 1) begin m_weoff = m_weon + 1; r = 1; end
        if (m_reoff < m_reon + 1) begin m_reoff = m_reon + 1; r = 1; end
        if (m_csoff < m_cson + 1) begin m_csoff = m_cson + 1; r = 1; end
        if (m_csoff < m_weoff) begin m_csoff = m_weoff; r = 1; end
        if (m_csoff < m_reoff) begin m_csoff = m_reoff; r = 1; end
        if (m_acc < m_reon + 1) begin m_acc = m_reon + 1; r = 1; end
        if (m_wrlen < m_weoff) begin m_wrlen = m_weoff; r = 1; end
        if (m_rdlen < m_reoff) begin m_rdlen = m_reoff; r = 1; end
        if (m_rdlen < m_acc) begin m_rdlen = m_acc; r = 1; end
        if (r) m_warn = 1;
    endtask

    // Model step at each rising edge, from the inputs stable before it
    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            int tl, len;
            bit lst, nd, nr, rdy;
            tl  = m_x2 ? 2 : 1;
            len = m_wr ? m_wrlen : m_rdlen;
            lst = m_busy && (m_clk == len * tl - 1);
            nd  = lst;
            nr  = lst && !m_wr;
            if (m_busy && !m_wr && m_clk == m_acc * tl - 1) m_rdata = rd_bus;
            rdy = !m_busy || lst;
            if (tim_load && !m_busy) m_load(tim_w0, tim_w1, tim_x2);
            m_evt = req_valid && rdy;
            if (m_evt) begin m_busy = 1; m_clk = 0; m_wr = req_write; end
            else if (lst) begin m_busy = 0; m_clk = 0; end
            else if (m_busy) m_clk++;
            m_done = nd; m_rdv = nr;
        end
        m_started = 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t (phase %s)",
                     req, what, act, exp, $time, phase);
        end
    endtask

    function automatic bit pin_exp(input bit en, input int tick, input int on, input int off, input bit pol);
        bit a = en && tick >= on && tick < off;
        return pol ? a : !a;
    endfunction

    // Compare every output 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (m_started && !finished) begin
                int tl, tick, len;
                tl = m_x2 ? 2 : 1;
                tick = m_clk / tl;
                len = m_wr ? m_wrlen : m_rdlen;
                chk("R2/R10", "cs_o", cs_o, pin_exp(m_busy, tick, m_cson, m_csoff, pol_cs));
                chk("R2/R10", "we_o", we_o, pin_exp(m_busy && m_wr, tick, m_weon, m_weoff, pol_we));
                chk("R2/R10", "re_o", re_o, pin_exp(m_busy && !m_wr, tick, m_reon, m_reoff, pol_re));
                chk("R8", "req_ready", req_ready, !m_busy || (m_clk == len * tl - 1));
                chk("R3", "done", done, m_done);
                chk("R7", "rd_valid", rd_valid, m_rdv);
                chk("R7", "rd_data", rd_data, m_rdata);
                chk("R6", "clamp_warn", clamp_warn, m_warn);
            end
        end
    end

    // Read bus changes every clock so the sampling edge is pinned down
    initial begin
        forever begin
            @(negedge clk);
            rd_bus = rd_bus * 16'd5 + 16'h3b1;
        end
    end

    function automatic logic [31:0] w0_of(int cson, int csoff, int weon, int weoff, int reon, int reoff);
        return (32'(cson) & 32'hF) | ((32'(csoff) & 32'h3F) << 4) | ((32'(weon) & 32'hF) << 10) |
               ((32'(weoff) & 32'h3F) << 14) | ((32'(reon) & 32'hF) << 20) | ((32'(reoff) & 32'h3F) << 24);
    endfunction
    function automatic logic [31:0] w1_of(int wl, int rl, int ac);
        return (32'(wl) & 32'h3F) | ((32'(rl) & 32'h3F) << 6) | ((32'(ac) & 32'h3F) << 22);
    endfunction

    task automatic load(input logic [31:0] w0, input logic [31:0] w1, input bit x2);
        @(negedge clk);
        tim_load = 1; tim_w0 = w0; tim_w1 = w1; tim_x2 = x2;
        @(negedge clk);
        tim_load = 0;
    endtask

    task automatic issue(input bit wr);
        @(negedge clk);
        req_valid = 1; req_write = wr;
        do begin @(posedge clk); #1; end while (!m_evt);
    endtask

    task automatic settle(input int n);
        @(negedge clk);
        req_valid = 0;
        do begin @(posedge clk); #1; end while (m_busy);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired (phase %s)", phase);
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R11: default timing, one read and one write
        issue(0); settle(2);
        issue(1); settle(2);

        phase = "R1 R2 R3 legal timing";
        load(w0_of(1, 9, 2, 6, 3, 7) | 32'hC000_0000, w1_of(10, 12, 5) | 32'hF03F_F000, 0);
        issue(1); settle(3);
        issue(0); settle(3);

        phase = "R8 back-to-back";
        issue(1); issue(0); issue(0); issue(1); settle(2);

        phase = "R4 two clocks per tick";
        load(w0_of(0, 5, 1, 3, 2, 4), w1_of(4, 6, 3), 1);
        issue(0); issue(1); issue(0); settle(2);

        phase = "R10 polarity";
        @(negedge clk); pol_cs = 1; pol_we = 0; pol_re = 1;
        issue(1); issue(0); settle(2);
        @(negedge clk); pol_cs = 0; pol_we = 1; pol_re = 0;
        issue(0); issue(1); settle(2);

        phase = "R9 load while busy";
        load(w0_of(2, 20, 3, 18, 4, 19), w1_of(30, 30, 10), 0);
        issue(1);
        load(w0_of(0, 1, 0, 1, 0, 1), w1_of(1, 1, 1), 1);
        settle(1);
        issue(0); settle(2);

        phase = "R5 clamp all zero";
        load(32'h0, 32'h0, 0);
        issue(0); issue(1); settle(2);
        phase = "R5 clamp ordering";
        load(w0_of(9, 2, 6, 4, 7, 3), w1_of(2, 3, 5), 0);
        issue(1); issue(0); settle(2);
        load(w0_of(1, 10, 2, 8, 15, 20), w1_of(40, 21, 30), 1);
        issue(0); settle(2);

        phase = "R6 warn sticky after legal load";
        load(w0_of(0, 4, 1, 3, 1, 3), w1_of(5, 5, 2), 0);
        issue(0); settle(2);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        phase = "R11 second reset";
        issue(0); issue(1); settle(3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule